// File: doc/BRIEF.md
# UART FIFO Trigger Flag Controller

This block sits between a host register bus and the bit-level engine of a serial port. It holds a transmit byte queue and a receive byte queue, both 16 deep. It also keeps a set of status flags that tell software when to refill or drain them. The refill flag and the drain flag are level-qualified against thresholds that software selects. A flag that software clears returns at once if its occupancy condition still holds, so a driver clears it only after it has moved enough bytes.

On the serial side, the block offers the head of the transmit queue to a serializer with a valid/ready pair. It accepts received characters together with their framing and parity error indications. A character of all zero bits with a framing error is a break. The break stops received characters from entering the queue until the raw receive line goes high again. The receiver keeps reporting its error indications while the break lasts. The raw line level is visible in the status word, so software can confirm the break.

Register map (3-bit address): 0 = data (a write pushes to the transmit queue, a read pops the receive queue), 1 = control, 2 = status, 3 = transmit count, 4 = receive count.

Top module: `uart_fifo_flags`

## Requirements
- R1: Status bit 0 (refill flag) becomes 1 whenever the transmit count is at or below the threshold picked by control bits [1:0] (0→8, 1→4, 2→2, 3→0). It is 1 after reset. Output irq_tx equals this flag.
- R2: Status bit 1 (drain flag) becomes 1 whenever the receive count is at or above the threshold picked by control bits [3:2] (0→1, 1→4, 2→8, 3→14). Output irq_rx equals this flag.
- R3: A flag in status bits [5:0] is cleared only by writing 0 to its bit after a status read that returned it as 1. Writing 0 without that read has no effect, and writing 1 never changes a flag. If the flag's setting condition holds in the clearing cycle, the flag stays 1.
- R4: Addresses 3 and 4 return the transmit and receive counts (0 after reset). Both queues are first-in first-out. Control reads back its 4 written bits and is 0 after reset.
- R5: tx_valid is high while the transmit queue is non-empty, and tx_byte shows its oldest byte. A cycle with tx_valid and tx_ready removes that byte.
- R6: A data write to a full transmit queue is dropped. A data read of an empty receive queue returns 0 and leaves the count at 0.
- R7: A character that arrives outside a break while the receive queue is full is dropped and sets status bit 5 (overrun).
- R8: A received character with rx_ferr sets status bit 2, and one with rx_perr sets status bit 3. A non-break character is still stored.
- R9: A character with value 0 and rx_ferr sets status bit 4 (break) and is not stored. Later characters are not stored until the break ends, but they still set bits 2 and 3.
- R10: The break ends in a cycle with rxd_line high. Characters are stored again after that.
- R11: Status bit 6 reads the present level of rxd_line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops data, arms status clears) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_tx | output | 1 | Refill request (status bit 0) |
| irq_rx | output | 1 | Drain request (status bit 1) |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Serializer takes tx_byte |
| rx_valid | input | 1 | Received character present |
| rx_byte | input | 8 | Received character |
| rx_ferr | input | 1 | Character had no stop bit |
| rx_perr | input | 1 | Character had a parity error |
| rxd_line | input | 1 | Raw receive line level |

## Verification
The bench builds the block with its default depth of 16 and 8-bit data. At that depth every occupancy from empty to full can be reached for every one of the four threshold selects on both queues. Each of those points gets a clear-then-reread of the flag, so the set-again rule is tested at every boundary. The full queues also bring the dropped write, the overrun and the in-order drain within reach, and the same holds for entry into and exit from a break.

// File: rtl/uart_fifo_flags.sv
module uart_fifo_flags #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          tx_valid,
  output logic [DW-1:0] tx_byte,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_ferr,
  input  logic          rx_perr,
  input  logic          rxd_line
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NF = 6;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);
  localparam logic [AW-1:0] A_TXC  = AW'(3);
  localparam logic [AW-1:0] A_RXC  = AW'(4);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0]    ctrl;
  logic [NF-1:0] flags, armed;
  logic          in_brk;

  logic [CW-1:0] tx_thr, rx_thr;
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic          brk_evt, ovr_evt, rx_take, rd_stat;
  logic [NF-1:0] set_v, clr_v, flags_n;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (ctrl[1:0])
      2'd0: tx_thr = CW'(DEPTH / 2);
      2'd1: tx_thr = CW'(DEPTH / 4);
      2'd2: tx_thr = CW'(DEPTH / 8);
      default: tx_thr = '0;
    endcase
    case (ctrl[3:2])
      2'd0: rx_thr = CW'(1);
      2'd1: rx_thr = CW'(DEPTH / 4);
      2'd2: rx_thr = CW'(DEPTH / 2);
      default: rx_thr = CW'(DEPTH - 2);
    endcase
  end

  assign tx_valid = (tx_cnt != '0);
  assign tx_byte  = tx_mem[tx_rp];
  assign tx_push  = wr_en && (addr == A_DATA) && (tx_cnt != FULL);
  assign tx_pop   = tx_valid && tx_ready;

  assign brk_evt  = rx_valid && rx_ferr && (rx_byte == '0);
  assign rx_take  = rx_valid && !in_brk && !brk_evt;
  assign rx_push  = rx_take && (rx_cnt != FULL);
  assign ovr_evt  = rx_take && (rx_cnt == FULL);
  assign rx_pop   = rd_en && (addr == A_DATA) && (rx_cnt != '0);
  assign rd_stat  = rd_en && (addr == A_STAT);

  assign set_v = {ovr_evt, brk_evt, rx_valid && rx_perr, rx_valid && rx_ferr,
                  rx_cnt >= rx_thr, tx_cnt <= tx_thr};
  assign clr_v = (wr_en && addr == A_STAT) ? (armed & ~wdata[NF-1:0]) : '0;
  assign flags_n = set_v | (flags & ~clr_v);

  assign irq_tx = flags[0];
  assign irq_rx = flags[1];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      tx_cnt <= '0;
      rx_cnt <= '0;
      ctrl   <= '0;
      flags  <= NF'(1);
      armed  <= '0;
      in_brk <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (wr_en && addr == A_CTRL) ctrl <= wdata[3:0];
      flags  <= flags_n;
      armed  <= ((rd_stat ? flags : '0) | (armed & ~clr_v)) & flags_n;
      if (brk_evt)       in_brk <= 1'b1;
      else if (rxd_line) in_brk <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DATA: rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
      A_CTRL: rdata = DW'(ctrl);
      A_STAT: rdata = DW'({rxd_line, flags});
      A_TXC:  rdata = DW'(tx_cnt);
      A_RXC:  rdata = DW'(rx_cnt);
      default: rdata = '0;
    endcase
  end
endmodule

module uart_fifo_flags_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_thr,
  input logic [CW-1:0] rx_thr,
  input logic          te,
  input logic          rf,
  input logic          in_brk,
  input logic          rx_valid,
  input logic          data_wr,
  input logic          tx_ready
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // R1
  te_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= tx_thr) |=> te);
  // R2
  rf_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= rx_thr) |=> rf);
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL) && (rx_cnt <= FULL));
  // R6
  full_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_cnt == FULL && !tx_ready) |=> (tx_cnt == FULL));
  // R9
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_brk && rx_valid) |=> (rx_cnt <= $past(rx_cnt)));
endmodule

bind uart_fifo_flags uart_fifo_flags_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_thr(tx_thr), .rx_thr(rx_thr), .te(flags[0]), .rf(flags[1]),
  .in_brk(in_brk), .rx_valid(rx_valid),
  .data_wr(wr_en && addr == 3'd0), .tx_ready(tx_ready)
);

// File: tb/test_uart_fifo_flags.sv
module test_uart_fifo_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 0, rd_en = 0, tx_ready = 0, rx_valid = 0, rx_ferr = 0, rx_perr = 0, rxd_line = 1;
  logic [7:0] wdata = '0, rx_byte = '0, rdata, tx_byte;
  logic irq_tx, irq_rx, tx_valid;
  int n_chk = 0, n_bad = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  uart_fifo_flags i_uart_fifo_flags (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ferr(rx_ferr),
    .rx_perr(rx_perr), .rxd_line(rxd_line));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rx_in(input logic [7:0] b, input logic fe, input logic pe);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_ferr = fe; rx_perr = pe;
    @(negedge clk); rx_valid = 0; rx_ferr = 0; rx_perr = 0;
  endtask

  function automatic int tx_t(input int s);
    return s == 0 ? 8 : s == 1 ? 4 : s == 2 ? 2 : 0;
  endfunction
  function automatic int rx_t(input int s);
    return s == 0 ? 1 : s == 1 ? 4 : s == 2 ? 8 : 14;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd2, v); check(v[5:0] == 6'h01, "R1 reset status", v, 1);
    check(irq_tx == 1, "R1 irq_tx reset", irq_tx, 1);
    rd(3'd3, v); check(v == 0, "R4 reset txcnt", v, 0);
    rd(3'd4, v); check(v == 0, "R4 reset rxcnt", v, 0);
    rd(3'd1, v); check(v == 0, "R4 reset ctrl", v, 0);

    // R3: clear without prior read has no effect
    rx_in(8'h33, 1, 0);
    wr(3'd2, 8'h7B);
    rd(3'd2, v); check(v[2] == 1, "R3 clear without read", v[2], 1);
    check(v[1] == 1, "R2 one byte sel0", v[1], 1);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); check(v[2] == 1, "R3 write one keeps", v[2], 1);
    wr(3'd2, 8'h7B);
    rd(3'd2, v); check(v[2] == 0, "R3 read then clear", v[2], 0);
    rd(3'd4, v); check(v == 1, "R8 ferr byte stored", v, 1);
    rd(3'd0, v); check(v == 8'h33, "R8 stored value", v, 8'h33);
    rd(3'd2, v); wr(3'd2, 8'h7D);

    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 8'(s));
      rd(3'd1, v); check(v == 8'(s), "R4 ctrl readback", v, s);
      for (int n = 0; n <= 16; n++) begin
        rd(3'd3, v); check(v == 8'(n < 16 ? n : 16), "R4 txcnt", v, n);
        rd(3'd2, v); wr(3'd2, 8'h7E); @(negedge clk);
        rd(3'd2, v);
        check(v[0] == (n <= tx_t(s)), "R1/R3 refill flag", v[0], n <= tx_t(s));
        check(irq_tx == v[0], "R1 irq_tx", irq_tx, v[0]);
        if (n < 16) wr(3'd0, 8'(s * 16 + n)); else wr(3'd0, 8'hEE);
      end
      rd(3'd3, v); check(v == 16, "R6 full write dropped", v, 16);
      @(negedge clk); tx_ready = 1;
      for (int k = 0; k < 16; k++) begin
        check(tx_valid && tx_byte == 8'(s * 16 + k), "R5 tx order", tx_byte, s * 16 + k);
        @(negedge clk);
      end
      tx_ready = 0;
      check(!tx_valid, "R5 tx empty", tx_valid, 0);
    end

    for (int s = 0; s < 4; s++) begin
      wr(3'd1, 8'(s << 2));
      for (int n = 0; n <= 16; n++) begin
        rd(3'd4, v); check(v == 8'(n), "R4 rxcnt", v, n);
        rd(3'd2, v); wr(3'd2, 8'h7D); @(negedge clk);
        rd(3'd2, v);
        check(v[1] == (n >= rx_t(s)), "R2/R3 drain flag", v[1], n >= rx_t(s));
        check(irq_rx == v[1], "R2 irq_rx", irq_rx, v[1]);
        if (n < 16) rx_in(8'(8'hA0 + n + s), 0, 0);
      end
      rx_in(8'h77, 0, 0);
      rd(3'd4, v); check(v == 16, "R7 full drop", v, 16);
      rd(3'd2, v); check(v[5] == 1, "R7 overrun flag", v[5], 1);
      wr(3'd2, 8'h5F);
      rd(3'd2, v); check(v[5] == 0, "R7 overrun cleared", v[5], 0);
      for (int k = 0; k < 16; k++) begin
        rd(3'd0, v); check(v == 8'(8'hA0 + k + s), "R4 rx order", v, 8'hA0 + k + s);
      end
      rd(3'd0, v); check(v == 0, "R6 empty read", v, 0);
      rd(3'd4, v); check(v == 0, "R6 empty count", v, 0);
      rd(3'd2, v); wr(3'd2, 8'h7D);
    end
    wr(3'd1, 8'h00);

    @(negedge clk); rxd_line = 0;
    rx_in(8'h00, 1, 0);
    rd(3'd2, v);
    check(v[4] == 1, "R9 break flag", v[4], 1);
    check(v[2] == 1, "R9 break framing flag", v[2], 1);
    check(v[6] == 0, "R11 raw line low", v[6], 0);
    rd(3'd4, v); check(v == 0, "R9 break not stored", v, 0);
    rd(3'd2, v); wr(3'd2, 8'h40);
    rd(3'd2, v); check(v[3:2] == 0, "R3 error flags cleared", v[3:2], 0);
    rx_in(8'h12, 0, 1);
    rd(3'd4, v); check(v == 0, "R9 held during break", v, 0);
    rd(3'd2, v); check(v[3] == 1, "R9 parity during break", v[3], 1);
    @(negedge clk); rxd_line = 1;
    @(negedge clk);
    rx_in(8'h5A, 0, 0);
    rd(3'd4, v); check(v == 1, "R10 storing resumes", v, 1);
    rd(3'd2, v); check(v[6] == 1, "R11 raw line high", v[6], 1);
    rd(3'd0, v); check(v == 8'h5A, "R10 resumed value", v, 8'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule